// File: doc/BRIEF.md
# CAN Receiver Event Flag Register

This block holds the receive-side event flags of a CAN controller and turns them into one interrupt request. It does not hold the protocol engine, the error counters or the message buffers. Four events are latched: bus wakeup, a change of the receiver or transmitter status, receive overrun and receive buffer full. Each event arrives as a one-clock set pulse, except the status change, which the block detects itself. Software clears a latched event by writing a 1 to its bit.

The same 8-bit view also shows two 2-bit status fields. They copy the receiver and transmitter status inputs and cannot be written. A second register holds one enable bit per event, and the interrupt request is raised while any enabled event is latched. During the controller's initialization handshake the event flags are forced to zero and flag writes are dropped. The status fields keep tracking their inputs during that time.

Top module: `can_rx_flag_reg`

## Requirements
- R1: After reset, both registers read 0x00 and the interrupt request is low.
- R2: In the flag register (address 0), the wakeup flag is bit 7, the status-change flag is bit 6, the overrun flag is bit 1 and the receive-full flag is bit 0. A set pulse makes its flag read 1 from the next clock onward.
- R3: A write to address 0 clears each event flag whose data bit is 1. A 0 in a data bit leaves that flag unchanged.
- R4: If a flag's set pulse arrives in the same cycle as a write that would clear it, the flag stays 1 because its cause is still present.
- R5: The receiver status shows in bits 5:4 and the transmitter status in bits 3:2. Both show the value their input had at the previous clock edge. Writes to these bits have no effect.
- R6: A change in the receiver or transmitter status input sets the status-change flag at the same edge that updates the field.
- R7: While the initialization request and acknowledge are both 1, all four event flags are held at 0, set pulses are lost and flag writes are ignored. The status fields keep following their inputs during this time.
- R8: Flag writes take effect only while both the request and the acknowledge are 0. While exactly one of them is 1, flag writes are ignored but set pulses still latch.
- R9: The enable register is at address 1. It keeps data bits 7, 6, 1 and 0 as the enables of the events in the matching flag positions, reads its other bits as 0, can be written at any time and resets to 0.
- R10: The interrupt request is high exactly when at least one event flag and its enable bit are both 1.
- R11: Read data is combinational from the selected register while the read strobe is high, and it is 0x00 while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_set | input | 1 | Wakeup event pulse |
| ovr_set | input | 1 | Receive overrun event pulse |
| rxf_set | input | 1 | Receive buffer full event pulse |
| rx_stat | input | 2 | Receiver status encoding |
| tx_stat | input | 2 | Transmitter status encoding |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register select: 0 = flags, 1 = enables |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the two half-handshake states, where only one of request and acknowledge is high. There, writes are blocked but events still latch, so a flag can be set and still resist clearing. The stimulus latches flags first and raises the request alone. It then writes and pulses in that state, completes the handshake, changes a status input while the flags are held, and lowers the two signals one at a time, writing between the two steps. A write in the same cycle as a set pulse covers the race between clearing and setting.

// File: rtl/rxflag_pkg.sv
package rxflag_pkg;
  localparam int REG_W  = 8;
  localparam int STAT_W = 2;
  localparam int NUM_EV = 4;

  // Event index to register bit position: 0 rx-full, 1 overrun, 2 status change, 3 wakeup
  function automatic int ev_bit_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/rxflag_event_bit.sv
module rxflag_event_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_q;

  always_comb begin
    q_d = q_q;
    if (hold_i)      q_d = 1'b0;
    else if (set_i)  q_d = 1'b1;
    else if (clr_i)  q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/rxflag_stat_track.sv
module rxflag_stat_track #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] tx_i,
  output logic [W-1:0] rx_o,
  output logic [W-1:0] tx_o,
  output logic         chg_o
);
  logic [W-1:0] rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      rx_q <= rx_i;
      tx_q <= tx_i;
    end
  end

  assign chg_o = (rx_i != rx_q) || (tx_i != tx_q);
  assign rx_o  = rx_q;
  assign tx_o  = tx_q;
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
  import rxflag_pkg::*;
#(
  parameter int ADDR_W    = 1,
  parameter int FLAG_ADDR = 0,
  parameter int IEN_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_set,
  input  logic              ovr_set,
  input  logic              rxf_set,
  input  logic [STAT_W-1:0] rx_stat,
  input  logic [STAT_W-1:0] tx_stat,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);

  logic              init_active, wr_open, flag_wr, ien_wr, stat_chg;
  logic [STAT_W-1:0] rx_view, tx_view;
  logic [NUM_EV-1:0] ev_set, ev_q, ien_d, ien_q, ien_wdata;
  logic [REG_W-1:0]  flag_view, ien_view;
  logic              unused_wr_bits;

  assign init_active    = init_req & init_ack;
  assign wr_open        = ~init_req & ~init_ack;
  assign flag_wr        = wr_en & wr_open & (addr == A_FLAG);
  assign ien_wr         = wr_en & (addr == A_IEN);
  assign unused_wr_bits = ^wr_data[5:2];

  rxflag_stat_track #(.W(STAT_W)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_i  (rx_stat),
    .tx_i  (tx_stat),
    .rx_o  (rx_view),
    .tx_o  (tx_view),
    .chg_o (stat_chg)
  );

  assign ev_set = {wake_set, stat_chg, ovr_set, rxf_set};

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    localparam int POS = ev_bit_pos(g);
    rxflag_event_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (init_active),
      .set_i  (ev_set[g]),
      .clr_i  (flag_wr & wr_data[POS]),
      .q_o    (ev_q[g])
    );
    assign ien_wdata[g] = wr_data[POS];
  end

  always_comb begin
    ien_d = ien_q;
    if (ien_wr) ien_d = ien_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  always_comb begin
    flag_view = '0;
    ien_view  = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      flag_view[ev_bit_pos(i)] = ev_q[i];
      ien_view[ev_bit_pos(i)]  = ien_q[i];
    end
    flag_view[5:4] = rx_view;
    flag_view[3:2] = tx_view;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == A_FLAG)     rd_data = flag_view;
      else if (addr == A_IEN) rd_data = ien_view;
    end
  end

  assign irq = |(ev_q & ien_q);
endmodule

// File: rtl/rxflag_checker.sv
module rxflag_checker #(
  parameter int ADDR_W    = 1,
  parameter int FLAG_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_set,
  input logic              rxf_set,
  input logic [1:0]        rx_stat,
  input logic [1:0]        tx_stat,
  input logic              init_req,
  input logic              init_ack,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              irq,
  input logic [3:0]        ev_q,
  input logic [3:0]        ien_q
);
  logic init_on, flag_sel, past_valid;
  assign init_on  = init_req && init_ack;
  assign flag_sel = (addr == ADDR_W'(FLAG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  p_rxf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_set && !init_on) |=> ev_q[0]);
  p_wake_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_set && !init_on) |=> ev_q[3]);
  p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[1] && !init_on && !(wr_en && flag_sel && wr_data[1])) |=> ev_q[1]);
  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_set && wr_en && flag_sel && wr_data[0] && !init_on) |=> ev_q[0]);
  p_status_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && rd_en && flag_sel) |-> (rd_data[5:2] == {$past(rx_stat), $past(tx_stat)}));
  p_init_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_on |=> (ev_q == 4'b0000));
  p_half_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[0] && (init_req || init_ack) && !init_on) |=> ev_q[0]);
  p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != 4'b0000));
endmodule

bind can_rx_flag_reg rxflag_checker #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wake_set (wake_set),
  .rxf_set  (rxf_set),
  .rx_stat  (rx_stat),
  .tx_stat  (tx_stat),
  .init_req (init_req),
  .init_ack (init_ack),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .irq      (irq),
  .ev_q     (ev_q),
  .ien_q    (ien_q)
);

// File: tb/sim_can_rx_flag_reg.sv
`timescale 1ns/1ps
module sim_can_rx_flag_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wake_set, ovr_set, rxf_set;
  logic [1:0] rx_stat, tx_stat;
  logic       init_req, init_ack, rd_en, wr_en;
  logic [0:0] addr;
  logic [7:0] wr_data, rd_data;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  can_rx_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .wake_set(wake_set), .ovr_set(ovr_set),
    .rxf_set(rxf_set), .rx_stat(rx_stat), .tx_stat(tx_stat),
    .init_req(init_req), .init_ack(init_ack), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference: event bits ordered wake, change, overrun, full
  bit [3:0] m_ev, m_ien;
  bit [1:0] m_rs, m_ts;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ev = 0; m_ien = 0; m_rs = 0; m_ts = 0;
    end else begin
      bit       blocked, writable, changed;
      bit [3:0] setv;
      bit [7:0] clrmask;
      blocked  = init_req && init_ack;
      writable = !init_req && !init_ack && wr_en && addr == 1'b0;
      changed  = (rx_stat != m_rs) || (tx_stat != m_ts);
      setv     = {wake_set, changed, ovr_set, rxf_set};
      clrmask  = writable ? wr_data : 8'h00;
      for (int k = 0; k < 4; k++) begin
        int pos;
        pos = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 6 : 7;
        if (blocked)           m_ev[k] = 1'b0;
        else if (setv[k])      m_ev[k] = 1'b1;
        else if (clrmask[pos]) m_ev[k] = 1'b0;
      end
      if (wr_en && addr == 1'b1)
        m_ien = {wr_data[7], wr_data[6], wr_data[1], wr_data[0]};
      m_rs = rx_stat;
      m_ts = tx_stat;
    end
  end

  function automatic logic [7:0] model_read();
    if (!rd_en) return 8'h00;
    if (addr == 1'b0) return {m_ev[3], m_ev[2], m_rs, m_ts, m_ev[1], m_ev[0]};
    return {m_ien[3], m_ien[2], 4'b0000, m_ien[1], m_ien[0]};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== model_read() || irq !== (|(m_ev & m_ien))) begin
        errors++;
        $display("FAIL %s model compare: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                 cur_req, rd_data, irq, model_read(), |(m_ev & m_ien));
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; addr = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wake_set = 0; ovr_set = 0; rxf_set = 0;
    rx_stat = 0; tx_stat = 0; init_req = 0; init_ack = 0;
    rd_en = 1'b1; wr_en = 0; addr = 0; wr_data = 0;
    #9;
    chk("R1", rd_data, 8'h00);
    addr = 1'b1; #1;
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'b0, irq}, 8'h00);
    addr = 1'b0;
    tick(); rst_n = 1'b1;
    tick(); tick();

    cur_req = "R2";
    rxf_set = 1; tick(); rxf_set = 0;
    chk("R2", rd_data, 8'h01);
    ovr_set = 1; tick(); ovr_set = 0;
    chk("R2", rd_data, 8'h03);
    wake_set = 1; tick(); wake_set = 0;
    chk("R2", rd_data, 8'h83);

    cur_req = "R3";
    wr(1'b0, 8'h00); chk("R3", rd_data, 8'h83);
    wr(1'b0, 8'h02); chk("R3", rd_data, 8'h81);
    wr(1'b0, 8'h80); chk("R3", rd_data, 8'h01);

    cur_req = "R4";
    rxf_set = 1; wr(1'b0, 8'h01); rxf_set = 0;
    chk("R4", rd_data, 8'h01);
    wr(1'b0, 8'h01); chk("R4", rd_data, 8'h00);

    cur_req = "R5";
    rx_stat = 2'b10; tx_stat = 2'b01; tick();
    chk("R5", {4'b0, rd_data[5:2]}, 8'h09);
    chk("R6", {7'b0, rd_data[6]}, 8'h01);
    wr(1'b0, 8'h3C); chk("R5", rd_data, 8'h64);
    wr(1'b0, 8'h40); chk("R6", rd_data, 8'h24);
    cur_req = "R6";
    tx_stat = 2'b11; tick();
    chk("R6", rd_data, 8'h6C);
    wr(1'b0, 8'h40); chk("R6", rd_data, 8'h2C);

    cur_req = "R8";
    rxf_set = 1; wake_set = 1; tick(); rxf_set = 0; wake_set = 0;
    chk("R2", rd_data, 8'hAD);
    init_req = 1; tick();
    chk("R8", rd_data, 8'hAD);
    wr(1'b0, 8'h81); chk("R8", rd_data, 8'hAD);
    ovr_set = 1; tick(); ovr_set = 0;
    chk("R8", rd_data, 8'hAF);

    cur_req = "R7";
    init_ack = 1; tick();
    chk("R7", rd_data, 8'h2C);
    rx_stat = 2'b01; tick();
    chk("R7", rd_data, 8'h1C);
    rxf_set = 1; tick(); rxf_set = 0;
    chk("R7", rd_data, 8'h1C);

    cur_req = "R8";
    init_req = 0; tick();
    rxf_set = 1; tick(); rxf_set = 0;
    chk("R8", rd_data, 8'h1D);
    wr(1'b0, 8'h01); chk("R8", rd_data, 8'h1D);
    init_ack = 0; tick();
    wr(1'b0, 8'h01); chk("R8", rd_data, 8'h1C);

    cur_req = "R9";
    addr = 1'b1; #1;
    chk("R9", rd_data, 8'h00);
    wr(1'b1, 8'hFF); addr = 1'b1; #1;
    chk("R9", rd_data, 8'hC3);
    addr = 1'b0;

    cur_req = "R10";
    chk("R10", {7'b0, irq}, 8'h00);
    rxf_set = 1; tick(); rxf_set = 0;
    chk("R10", {7'b0, irq}, 8'h01);
    wr(1'b1, 8'h80);
    chk("R10", {7'b0, irq}, 8'h00);
    wake_set = 1; tick(); wake_set = 0;
    chk("R10", {7'b0, irq}, 8'h01);

    cur_req = "R11";
    rd_en = 1'b0; #1;
    chk("R11", rd_data, 8'h00);
    addr = 1'b1; #1;
    chk("R11", rd_data, 8'h00);
    tick(); tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule